// File: doc/BRIEF.md
# Signed Four-Bit Comparator from Subtraction Flags

This block compares two 4-bit two's complement operands, X and Y, with no clock or storage. It forms X minus Y as X plus the bitwise inverse of Y plus one. The adder is a carry-lookahead adder. Every carry is a flat sum of products of per-bit generate and propagate terms, so no carry waits on the carry below it.

The difference yields four condition flags: carry, negative, zero and overflow. Five relation outputs come from the flags alone: equal, less, less-or-equal, greater-or-equal and greater. Because less is taken as the sign of the difference exclusive-ORed with the overflow flag, the relations hold for signed operands. That includes pairs whose true difference does not fit in four bits, such as -8 against 7.

The outputs are meant for a surrounding datapath that needs signed relations or raw flags within the same cycle.

Top module: `signed_cmp4`

## Requirements
- R1: `eq_o` is 1 exactly when X and Y hold the same value.
- R2: `lt_o` is 1 exactly when X is less than Y, both read as two's complement.
- R3: `le_o` is 1 exactly when X is less than or equal to Y (signed).
- R4: `ge_o` is 1 exactly when X is greater than or equal to Y (signed).
- R5: `gt_o` is 1 exactly when X is greater than Y (signed).
- R6: `nf_o` equals bit 3 of (X - Y) mod 16.
- R7: `zf_o` is 1 exactly when (X - Y) mod 16 is zero.
- R8: `cf_o` is the carry out of bit 3 of X + ~Y + 1. It is 1 exactly when X is greater than or equal to Y as unsigned 4-bit patterns.
- R9: `vf_o` is 1 exactly when the true signed difference X - Y lies outside -8..7.
- R10: Exactly one of `lt_o`, `eq_o`, `gt_o` is 1 for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 4 | Operand X, two's complement |
| y_i | input | 4 | Operand Y, two's complement |
| eq_o | output | 1 | X equals Y |
| lt_o | output | 1 | X less than Y, signed |
| le_o | output | 1 | X less than or equal to Y, signed |
| ge_o | output | 1 | X greater than or equal to Y, signed |
| gt_o | output | 1 | X greater than Y, signed |
| cf_o | output | 1 | Carry out of the subtraction |
| nf_o | output | 1 | Sign bit of the difference |
| zf_o | output | 1 | Difference is zero |
| vf_o | output | 1 | Signed overflow of the difference |

## Verification
The assertions are immediate checks evaluated whenever the combinational outputs change. They assume only that both operands are fully driven 0/1 values. The stimulus applies each operand pair for a whole cycle from fixed drive points, so no check sees a partial update. The stimulus covers every one of the 256 pairs, which includes the overflow corners -8 against 7 and 7 against -8.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  parameter int unsigned W = 4;
  localparam int unsigned MSB = W - 1;

  typedef struct packed {
    logic cf;
    logic nf;
    logic zf;
    logic vf;
  } flags_t;

  typedef struct packed {
    logic eq;
    logic lt;
    logic le;
    logic ge;
    logic gt;
  } rel_t;
endpackage

// File: rtl/cla_sub.sv
module cla_sub
  import cmp_pkg::*;
(
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] diff_o,
  output logic [W-1:0] carry_o
);
  logic [W-1:0] gen, prop, cin_bit;
  logic         cin;

  assign cin = 1'b1;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_gp
      assign gen[i]  = a_i[i] & ~b_i[i];
      assign prop[i] = a_i[i] ^ ~b_i[i];
    end
  endgenerate

  // flattened lookahead: carry i = OR over j of gen[j] & prop[i:j+1], plus prop[i:0] & cin
  always_comb begin
    for (int k = 0; k < W; k++) begin
      logic acc, term;
      term = cin;
      for (int m = 0; m <= k; m++) term = term & prop[m];
      acc = term;
      for (int j = 0; j <= k; j++) begin
        term = gen[j];
        for (int m = j + 1; m <= k; m++) term = term & prop[m];
        acc = acc | term;
      end
      carry_o[k] = acc;
    end
  end

  generate
    for (i = 0; i < W; i++) begin : g_sum
      if (i == 0) begin : g_lsb
        assign cin_bit[i] = cin;
      end else begin : g_up
        assign cin_bit[i] = carry_o[i-1];
      end
      assign diff_o[i] = prop[i] ^ cin_bit[i];
    end
  endgenerate

  always_comb begin
    a_r8_carry_unsigned: assert (carry_o[W-1] == (a_i >= b_i))
      else $error("carry out disagrees with unsigned order");
  end
endmodule

// File: rtl/flag_gen.sv
module flag_gen
  import cmp_pkg::*;
(
  input  logic [W-1:0] diff_i,
  input  logic [W-1:0] carry_i,
  output flags_t       flags_o
);
  assign flags_o.cf = carry_i[MSB];
  assign flags_o.nf = diff_i[MSB];
  assign flags_o.zf = ~|diff_i;
  assign flags_o.vf = carry_i[MSB] ^ carry_i[MSB-1];
endmodule

// File: rtl/rel_gen.sv
module rel_gen
  import cmp_pkg::*;
(
  input  flags_t flags_i,
  output rel_t   rel_o
);
  logic less;
  assign less      = flags_i.nf ^ flags_i.vf;
  assign rel_o.eq  = flags_i.zf;
  assign rel_o.lt  = less;
  assign rel_o.le  = less | flags_i.zf;
  assign rel_o.ge  = ~less;
  assign rel_o.gt  = ~(less | flags_i.zf);

  always_comb begin
    a_r10_one_relation: assert ($onehot({rel_o.lt, rel_o.eq, rel_o.gt}))
      else $error("not exactly one of lt/eq/gt");
  end
endmodule

// File: rtl/signed_cmp4.sv
module signed_cmp4
  import cmp_pkg::*;
(
  input  logic [3:0] x_i,
  input  logic [3:0] y_i,
  output logic       eq_o,
  output logic       lt_o,
  output logic       le_o,
  output logic       ge_o,
  output logic       gt_o,
  output logic       cf_o,
  output logic       nf_o,
  output logic       zf_o,
  output logic       vf_o
);
  logic [W-1:0] diff, carry;
  flags_t       flags;
  rel_t         rel;

  cla_sub u_sub (.a_i(x_i), .b_i(y_i), .diff_o(diff), .carry_o(carry));
  flag_gen u_flg (.diff_i(diff), .carry_i(carry), .flags_o(flags));
  rel_gen u_rel (.flags_i(flags), .rel_o(rel));

  assign eq_o = rel.eq;
  assign lt_o = rel.lt;
  assign le_o = rel.le;
  assign ge_o = rel.ge;
  assign gt_o = rel.gt;
  assign cf_o = flags.cf;
  assign nf_o = flags.nf;
  assign zf_o = flags.zf;
  assign vf_o = flags.vf;

  always_comb begin
    a_r7_zero_iff_equal: assert (zf_o == (x_i == y_i))
      else $error("zero flag wrong");
    a_r9_ovf_needs_sign_mismatch: assert (!vf_o || (x_i[3] != y_i[3]))
      else $error("overflow with matching signs");
    a_r2_signed_less: assert (lt_o == ($signed(x_i) < $signed(y_i)))
      else $error("signed less wrong");
    a_r6_sign_of_diff: assert (nf_o == diff[3])
      else $error("negative flag not difference sign");
  end
endmodule

// File: tb/sim_signed_cmp4.sv
module sim_signed_cmp4;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] x, y;
  logic eq, lt, le, ge, gt, cf, nf, zf, vf;

  signed_cmp4 u0 (.x_i(x), .y_i(y), .eq_o(eq), .lt_o(lt), .le_o(le), .ge_o(ge),
                  .gt_o(gt), .cf_o(cf), .nf_o(nf), .zf_o(zf), .vf_o(vf));

  typedef struct {
    logic [3:0] xv, yv;
    logic eq, lt, le, ge, gt, cf, nf, zf, vf;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0;
  bit driving_done = 0, mon_done = 0;

  task automatic chk(string req, logic [3:0] xv, logic [3:0] yv, logic act, logic expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s x=%0d y=%0d actual=%b expected=%b", req, $signed(xv), $signed(yv), act, expv);
    end
  endtask

  task automatic drive(logic [3:0] xv, logic [3:0] yv);
    exp_t e;
    int sx, sy, d;
    @(posedge clk);
    x = xv; y = yv;
    sx = $signed(xv); sy = $signed(yv); d = sx - sy;
    e.xv = xv; e.yv = yv;
    e.eq = (sx == sy); e.lt = (sx < sy); e.le = (sx <= sy);
    e.ge = (sx >= sy); e.gt = (sx > sy);
    e.cf = ({28'd0, xv} >= {28'd0, yv});
    e.nf = d[3];
    e.zf = (d[3:0] == 4'd0);
    e.vf = (d > 7) || (d < -8);
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk("R1", e.xv, e.yv, eq, e.eq);
        chk("R2", e.xv, e.yv, lt, e.lt);
        chk("R3", e.xv, e.yv, le, e.le);
        chk("R4", e.xv, e.yv, ge, e.ge);
        chk("R5", e.xv, e.yv, gt, e.gt);
        chk("R6", e.xv, e.yv, nf, e.nf);
        chk("R7", e.xv, e.yv, zf, e.zf);
        chk("R8", e.xv, e.yv, cf, e.cf);
        chk("R9", e.xv, e.yv, vf, e.vf);
        chk("R10", e.xv, e.yv, logic'(lt + eq + gt == 2'd1), 1'b1);
      end else if (driving_done) begin
        mon_done = 1;
      end
    end
  end

  initial begin : stimulus
    x = 4'd0; y = 4'd0;
    drive(4'd0, 4'd0);      // idle state: both zero
    drive(4'b1000, 4'b0111); // -8 vs 7: overflow corner
    drive(4'b0111, 4'b1000); // 7 vs -8: overflow corner
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        drive(4'(i), 4'(j));
    driving_done = 1;
  end

  initial begin : watchdog
    fork
      wait (mon_done);
      begin
        repeat (5000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule